// File: doc/BRIEF.md
# Prioritized Microcode Task Scheduler

This block decides which of sixteen microcode tasks owns a shared microsequencer on each clock. Device wakeup lines and per-task sticky Ready flags are priority-encoded into a registered best competing task. A switch takes place when that task outranks the running task, or when a running non-zero task blocks. Task 0, the background task, is always runnable. It has no Ready flag and cannot block.

The sequencer presents one instruction per clock. The block sees that instruction's BLOCK bit, its tasking-off and tasking-on controls, a software wakeup strobe, a dispatch flag and a saved-PC access. It also receives the instruction's own address and its tentative next address. It returns the address of the next instruction to fetch, and it asserts hold when it has to suspend the instruction. Each task's program counter is parked in a per-task array while the task is inactive. Any task can read that array, or write the slot of another task.

Top module: `utask_sched`

## Requirements
- R1: After reset the current task and the best-next task are both 0, no Ready flag is set, tasking is enabled, every saved PC and dispatch flag is 0, and neither switch_pend nor hold_out is asserted.
- R2: Task 15 has the highest priority. best_task is registered each clock as the highest-numbered task from 1 to 15 that has its wake_req bit or its Ready flag set, excluding the task that will run next. It is 0 when no such task exists. When switching is allowed, switch_pend is asserted whenever best_task is greater than cur_task.
- R3: cur_task takes the value of best_task at the clock edge that ends a cycle with switch_pend asserted, and changes at no other time. A wake_req bit first sampled at edge N shows up in best_task after edge N and in cur_task after edge N+1.
- R4: blk from a non-zero task, while switching is allowed and hold_in is low, clears that task's Ready flag and switches to best_task even if best_task is lower. blk from task 0 has no effect.
- R5: A task's Ready flag (tasks 1 to 15) is set by an executed software wakeup naming it, or when the task is switched out without blocking. Only R4 clears the flag.
- R6: An executed instruction with tsk_off disables switching until a later tsk_on. blk has no effect while switching is disabled.
- R7: When a switch is pending in a cycle that carries tsk_off, hold_out is asserted, the switch still happens, and tasking stays enabled. The address saved for the outgoing task is that instruction's own address (cia).
- R8: After an executed tsk_on (without tsk_off), the same task executes two more instructions before a switch is allowed. tsk_off takes precedence when both are set.
- R9: pc_rd_data shows the saved PC of task pc_acc_task. An executed write whose target differs from the current task stores pc_wr_data and clears that task's dispatch flag. A write to the current task is ignored. Each executed instruction loads the current task's dispatch flag from disp_set, and disp_pend shows the flag of the current task.
- R10: next_pc is the saved PC of best_task when switching, otherwise cia when held, otherwise tnia. On a switch the outgoing task's slot receives cia if held, or tnia if not.
- R11: While hold_in is high the instruction has no effect (blk, software wakeup, tasking controls, PC write and dispatch flag are all ignored). A switch to a higher-priority task still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_req | input | NTASK | Device wakeup lines, one per task |
| swk_vld | input | 1 | Software wakeup strobe in this instruction |
| swk_task | input | TW | Task named by the software wakeup |
| blk | input | 1 | BLOCK bit of this instruction |
| tsk_off | input | 1 | Disable task switching |
| tsk_on | input | 1 | Re-enable task switching (delayed) |
| hold_in | input | 1 | External hold of this instruction |
| cia | input | PCW | Address of this instruction |
| tnia | input | PCW | Tentative next address of the running task |
| disp_set | input | 1 | Instruction starts a dispatch for its task |
| pc_acc_task | input | TW | Task whose saved PC is read or written |
| pc_wr_en | input | 1 | Write pc_wr_data into the selected saved PC |
| pc_wr_data | input | PCW | Saved-PC write data |
| cur_task | output | TW | Task executing the current instruction |
| best_task | output | TW | Registered best competing task |
| switch_pend | output | 1 | A task switch takes place at the next edge |
| hold_out | output | 1 | Current instruction is held |
| next_pc | output | PCW | Address of the next instruction to fetch |
| pc_rd_data | output | PCW | Saved PC of pc_acc_task |
| disp_pend | output | 1 | Dispatch flag of the current task |

## Verification
A Ready flag set or cleared wrongly is not visible until the encoder picks a winner. It shows in best_task one cycle after the faulty edge, and in cur_task one cycle after that, usually as a return to a task that blocked or a task that is never resumed. A tasking-enable or delay counter that is off by a cycle shows as switch_pend rising one instruction early or late after tsk_on or tsk_off. A wrong saved-PC slot remains hidden until the task is resumed or its slot is read, and then it appears on next_pc or pc_rd_data. The bench therefore compares all outputs against a reference model on every cycle, so that a fault is caught at the first cycle it reaches a port.

// File: rtl/utask_pkg.sv
package utask_pkg;
  // Source of the next fetch address.
  typedef enum logic [1:0] {
    NA_SEQ    = 2'd0,
    NA_HELD   = 2'd1,
    NA_RESUME = 2'd2
  } na_src_e;
endpackage

// File: rtl/sched_prio_enc.sv
module sched_prio_enc #(
  parameter int N = 16,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] idx
);
  // Highest set bit wins; an empty vector yields index 0.
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/sched_pc_file.sv
module sched_pc_file #(
  parameter int N   = 16,
  parameter int PCW = 12,
  parameter int W   = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sv_en,
  input  logic [W-1:0]   sv_idx,
  input  logic [PCW-1:0] sv_data,
  input  logic           wr_en,
  input  logic [W-1:0]   wr_idx,
  input  logic [PCW-1:0] wr_data,
  input  logic           dp_en,
  input  logic [W-1:0]   dp_idx,
  input  logic           dp_val,
  input  logic [W-1:0]   rd_idx,
  output logic [PCW-1:0] rd_data,
  input  logic [W-1:0]   rs_idx,
  output logic [PCW-1:0] rs_data,
  input  logic [W-1:0]   dq_idx,
  output logic           dq_flag
);
  logic [PCW-1:0] pc_q [N];
  logic [N-1:0]   dp_q;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic sv_hit, wr_hit, dp_hit;
    assign sv_hit = sv_en && (sv_idx == W'(g));
    assign wr_hit = wr_en && (wr_idx == W'(g));
    assign dp_hit = dp_en && (dp_idx == W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q[g] <= '0;
        dp_q[g] <= 1'b0;
      end else begin
        if (sv_hit)      pc_q[g] <= sv_data;
        else if (wr_hit) pc_q[g] <= wr_data;
        if (dp_hit)      dp_q[g] <= dp_val;
        else if (wr_hit) dp_q[g] <= 1'b0;
      end
    end
  end

  assign rd_data = pc_q[rd_idx];
  assign rs_data = pc_q[rs_idx];
  assign dq_flag = dp_q[dq_idx];
endmodule

// File: rtl/utask_sched.sv
module utask_sched #(
  parameter int NTASK  = 16,
  parameter int PCW    = 12,
  parameter int ON_GAP = 2,
  localparam int TW    = $clog2(NTASK),
  localparam int DW    = $clog2(ON_GAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTASK-1:0] wake_req,
  input  logic             swk_vld,
  input  logic [TW-1:0]    swk_task,
  input  logic             blk,
  input  logic             tsk_off,
  input  logic             tsk_on,
  input  logic             hold_in,
  input  logic [PCW-1:0]   cia,
  input  logic [PCW-1:0]   tnia,
  input  logic             disp_set,
  input  logic [TW-1:0]    pc_acc_task,
  input  logic             pc_wr_en,
  input  logic [PCW-1:0]   pc_wr_data,
  output logic [TW-1:0]    cur_task,
  output logic [TW-1:0]    best_task,
  output logic             switch_pend,
  output logic             hold_out,
  output logic [PCW-1:0]   next_pc,
  output logic [PCW-1:0]   pc_rd_data,
  output logic             disp_pend
);
  import utask_pkg::*;

  logic [TW-1:0]    cur_q, cur_d, bnt_q, bnt_d;
  logic             ten_q, ten_d;
  logic [DW-1:0]    gap_q, gap_d;
  logic [NTASK-1:0] rdy_q, rdy_d, cand;
  logic             allow, higher, blk_ok, sw, held, exe;
  logic [PCW-1:0]   resume_pc, save_pc;
  na_src_e          nsrc;

  // Switch decision for the instruction in flight.
  always_comb begin
    allow  = ten_q && (gap_q == '0);
    higher = bnt_q > cur_q;
    blk_ok = blk && (cur_q != '0) && allow && !hold_in;
    sw     = allow && (higher || blk_ok);
    held   = hold_in || (sw && tsk_off);
    exe    = !held;
  end

  // Ready flags and tasking enable next state.
  always_comb begin
    rdy_d = rdy_q;
    if (blk_ok) rdy_d[cur_q] = 1'b0;
    if (sw && !blk_ok && (cur_q != '0)) rdy_d[cur_q] = 1'b1;
    if (exe && swk_vld && (swk_task != '0)) rdy_d[swk_task] = 1'b1;

    ten_d = ten_q;
    gap_d = gap_q;
    if (exe && (gap_q != '0)) gap_d = gap_q - 1'b1;
    if (exe && tsk_off) begin
      ten_d = 1'b0;
    end else if (exe && tsk_on) begin
      ten_d = 1'b1;
      gap_d = DW'(ON_GAP);
    end

    cur_d = sw ? bnt_q : cur_q;
    cand  = wake_req | rdy_d;
    cand[0]     = 1'b0;
    cand[cur_d] = 1'b0;
  end

  sched_prio_enc #(.N(NTASK), .W(TW)) u_enc (
    .req (cand),
    .idx (bnt_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      bnt_q <= '0;
      ten_q <= 1'b1;
      gap_q <= '0;
      rdy_q <= '0;
    end else begin
      cur_q <= cur_d;
      bnt_q <= bnt_d;
      ten_q <= ten_d;
      gap_q <= gap_d;
      rdy_q <= rdy_d;
    end
  end

  assign save_pc = held ? cia : tnia;

  sched_pc_file #(.N(NTASK), .PCW(PCW), .W(TW)) u_pcf (
    .clk     (clk),
    .rst_n   (rst_n),
    .sv_en   (sw),
    .sv_idx  (cur_q),
    .sv_data (save_pc),
    .wr_en   (exe && pc_wr_en && (pc_acc_task != cur_q)),
    .wr_idx  (pc_acc_task),
    .wr_data (pc_wr_data),
    .dp_en   (exe),
    .dp_idx  (cur_q),
    .dp_val  (disp_set),
    .rd_idx  (pc_acc_task),
    .rd_data (pc_rd_data),
    .rs_idx  (bnt_q),
    .rs_data (resume_pc),
    .dq_idx  (cur_q),
    .dq_flag (disp_pend)
  );

  always_comb begin
    if (sw)        nsrc = NA_RESUME;
    else if (held) nsrc = NA_HELD;
    else           nsrc = NA_SEQ;
    case (nsrc)
      NA_RESUME: next_pc = resume_pc;
      NA_HELD:   next_pc = cia;
      default:   next_pc = tnia;
    endcase
  end

  assign cur_task    = cur_q;
  assign best_task   = bnt_q;
  assign switch_pend = sw;
  assign hold_out    = held;
endmodule

// File: rtl/utask_sched_chk.sv
module utask_sched_chk #(
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          blk,
  input logic          tsk_off,
  input logic          tsk_on,
  input logic          hold_in,
  input logic [TW-1:0] cur_task,
  input logic [TW-1:0] best_task,
  input logic          switch_pend,
  input logic          hold_out
);
  assert_task_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_task != $past(cur_task)) |-> $past(switch_pend));

  assert_task_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pend |=> (cur_task == $past(best_task)));

  assert_lower_by_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_pend && (best_task < cur_task)) |-> (blk && !hold_in));

  assert_off_atomic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tsk_off && !hold_out) |=> !switch_pend);

  assert_hold_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_out && !hold_in) |-> (switch_pend && tsk_off));

  assert_on_gap1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tsk_on && !tsk_off && !hold_out) |=> !switch_pend);

  assert_on_gap2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tsk_on && !tsk_off && !hold_out) |=> ##1 !switch_pend);
endmodule

bind utask_sched utask_sched_chk #(.TW(TW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .blk         (blk),
  .tsk_off     (tsk_off),
  .tsk_on      (tsk_on),
  .hold_in     (hold_in),
  .cur_task    (cur_task),
  .best_task   (best_task),
  .switch_pend (switch_pend),
  .hold_out    (hold_out)
);

// File: tb/utask_sched_tb.sv
module utask_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 16;
  localparam int PW = 12;
  localparam int TW = 4;

  logic clk, rst_n;
  logic [NT-1:0] wake_req;
  logic swk_vld, blk, tsk_off, tsk_on, hold_in, disp_set, pc_wr_en;
  logic [TW-1:0] swk_task, pc_acc_task;
  logic [PW-1:0] cia, tnia, pc_wr_data;
  logic [TW-1:0] cur_task, best_task;
  logic switch_pend, hold_out, disp_pend;
  logic [PW-1:0] next_pc, pc_rd_data;

  utask_sched u_dut (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .swk_vld(swk_vld),
    .swk_task(swk_task), .blk(blk), .tsk_off(tsk_off), .tsk_on(tsk_on),
    .hold_in(hold_in), .cia(cia), .tnia(tnia), .disp_set(disp_set),
    .pc_acc_task(pc_acc_task), .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data),
    .cur_task(cur_task), .best_task(best_task), .switch_pend(switch_pend),
    .hold_out(hold_out), .next_pc(next_pc), .pc_rd_data(pc_rd_data),
    .disp_pend(disp_pend)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // Reference model state.
  int m_cur, m_bnt, m_gap;
  bit m_ten;
  bit m_rdy [NT];
  int m_pc  [NT];
  bit m_dp  [NT];
  bit c_sw, c_held, c_blk;
  int c_next;

  function void mcomb();
    bit allow;
    allow  = m_ten && (m_gap == 0);
    c_blk  = blk && (m_cur != 0) && allow && !hold_in;
    c_sw   = allow && ((m_bnt > m_cur) || c_blk);
    c_held = hold_in || (c_sw && tsk_off);
    c_next = c_sw ? m_pc[m_bnt] : (c_held ? int'(cia) : int'(tnia));
  endfunction

  function void mstep();
    bit exe;
    int t;
    mcomb();
    exe = !c_held;
    if (c_sw) m_pc[m_cur] = c_held ? int'(cia) : int'(tnia);
    t = int'(pc_acc_task);
    if (exe && pc_wr_en && t != m_cur) begin
      m_pc[t] = int'(pc_wr_data);
      m_dp[t] = 0;
    end
    if (exe) m_dp[m_cur] = disp_set;
    if (c_blk) m_rdy[m_cur] = 0;
    if (c_sw && !c_blk && m_cur != 0) m_rdy[m_cur] = 1;
    if (exe && swk_vld && swk_task != 0) m_rdy[swk_task] = 1;
    if (exe && m_gap > 0) m_gap--;
    if (exe && tsk_off) m_ten = 0;
    else if (exe && tsk_on) begin
      m_ten = 1;
      m_gap = 2;
    end
    if (c_sw) m_cur = m_bnt;
    m_bnt = 0;
    for (int k = NT - 1; k >= 1; k--) begin
      if (m_bnt == 0 && k != m_cur && (wake_req[k] || m_rdy[k])) m_bnt = k;
    end
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    mcomb();
    chk("R3", "cur_task", int'(cur_task), m_cur);
    chk("R2", "best_task", int'(best_task), m_bnt);
    chk("R2", "switch_pend", int'(switch_pend), int'(c_sw));
    chk("R7", "hold_out", int'(hold_out), int'(c_held));
    chk("R10", "next_pc", int'(next_pc), c_next);
    chk("R9", "pc_rd_data", int'(pc_rd_data), m_pc[pc_acc_task]);
    chk("R9", "disp_pend", int'(disp_pend), int'(m_dp[m_cur]));
  endtask

  // One instruction: inputs already set, compare mid-cycle, advance.
  task automatic cyc();
    #1 compare_all();
    @(posedge clk);
    mstep();
    @(negedge clk);
  endtask

  task automatic quiet();
    swk_vld = 0; blk = 0; tsk_off = 0; tsk_on = 0; hold_in = 0;
    disp_set = 0; pc_wr_en = 0;
  endtask

  initial begin
    rst_n = 0; wake_req = '0; swk_task = '0; pc_acc_task = '0;
    cia = '0; tnia = '0; pc_wr_data = '0;
    quiet();
    m_cur = 0; m_bnt = 0; m_gap = 0; m_ten = 1;
    for (int k = 0; k < NT; k++) begin
      m_rdy[k] = 0; m_pc[k] = 0; m_dp[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "reset cur_task", int'(cur_task), 0);
    chk("R1", "reset best_task", int'(best_task), 0);
    chk("R1", "reset switch_pend", int'(switch_pend), 0);
    chk("R1", "reset hold_out", int'(hold_out), 0);
    chk("R1", "reset disp_pend", int'(disp_pend), 0);
    @(negedge clk);

    // Background task cannot block.
    blk = 1; cia = 12'h010; tnia = 12'h011;
    cyc();
    chk("R4", "task0 blk ignored", int'(cur_task), 0);
    blk = 0;

    // Wakeup latency.
    wake_req = 16'h0020;
    cyc();
    chk("R3", "best after one edge", int'(best_task), 5);
    chk("R3", "cur after one edge", int'(cur_task), 0);
    cyc();
    chk("R3", "cur after two edges", int'(cur_task), 5);

    // Preemption leaves task 5 ready; block of 12 returns to 5.
    tnia = 12'h0A0;
    wake_req = 16'h1020;
    cyc(); cyc();
    chk("R2", "higher task preempts", int'(cur_task), 12);
    wake_req = '0; blk = 1;
    cyc();
    chk("R5", "return to preempted ready task", int'(cur_task), 5);
    blk = 0;

    // Tasking off with pending switch is held.
    wake_req = 16'h1000;
    cyc();
    tsk_off = 1; cia = 12'h155; tnia = 12'h156;
    #1 chk("R7", "hold on off+switch", int'(hold_out), 1);
    cyc();
    chk("R7", "switch still taken", int'(cur_task), 12);
    tsk_off = 0; wake_req = '0; blk = 1; cia = 12'h300; tnia = 12'h301;
    #1 chk("R7", "held address resumes", int'(next_pc), 12'h155);
    cyc();
    blk = 0;

    // Tasking off: block ignored, no preemption; tasking on delay.
    tsk_off = 1;
    cyc();
    tsk_off = 0; wake_req = 16'h1000; blk = 1;
    cyc();
    chk("R6", "blk ignored with tasking off", int'(cur_task), 5);
    blk = 0;
    cyc();
    chk("R6", "no preempt with tasking off", int'(cur_task), 5);
    tsk_on = 1;
    cyc();
    chk("R8", "on instruction", int'(cur_task), 5);
    tsk_on = 0;
    cyc();
    chk("R8", "first after on", int'(cur_task), 5);
    cyc();
    chk("R8", "second after on", int'(cur_task), 5);
    cyc();
    chk("R8", "switch after gap", int'(cur_task), 12);

    // Saved PC access.
    pc_acc_task = 4'd3; pc_wr_en = 1; pc_wr_data = 12'h2A5;
    cyc();
    pc_wr_en = 0;
    #1 chk("R9", "write other task", int'(pc_rd_data), 12'h2A5);
    pc_acc_task = 4'd12; pc_wr_en = 1; pc_wr_data = 12'h777;
    cyc();
    pc_wr_en = 0;
    #1 chk("R9", "write own task ignored", int'(pc_rd_data), m_pc[12]);

    // External hold.
    hold_in = 1; blk = 1; cia = 12'h111; tnia = 12'h222;
    #1 chk("R11", "held next_pc", int'(next_pc), 12'h111);
    cyc();
    chk("R11", "blk ignored under hold", int'(cur_task), 12);
    blk = 0; wake_req = 16'h5000;
    cyc(); cyc();
    chk("R11", "higher task during hold", int'(cur_task), 14);
    quiet();

    // Random traffic.
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 8) == 0) wake_req[$urandom % NT] = ~wake_req[$urandom % NT];
      swk_vld  = ($urandom % 20) == 0;
      swk_task = TW'($urandom);
      blk      = ($urandom % 6) == 0;
      tsk_off  = ($urandom % 25) == 0;
      tsk_on   = ($urandom % 10) == 0;
      hold_in  = ($urandom % 10) == 0;
      disp_set = ($urandom % 5) == 0;
      pc_wr_en = ($urandom % 15) == 0;
      pc_acc_task = TW'($urandom);
      pc_wr_data  = PW'($urandom);
      cia  = PW'($urandom);
      tnia = PW'($urandom);
      cyc();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule